// File: doc/BRIEF.md
# Shadowed Reload PWM Timer

This block is an up-counting timer that drives one pulse-width-modulated output. Software programs it through single-cycle register writes: a select code picks the run-control register, the live counter, the reload value or the compare value. The counter climbs from the reload value to its all-ones maximum and then wraps back to the reload value, so the reload value sets the period. The compare value sets the point in each period where the output drops, so it sets the high time.

The reload and compare values can be rewritten while the timer runs. Writes go to a pair of holding registers. Both holding registers are copied into the working registers on the same edge that wraps the counter. The period in progress therefore always finishes with its old settings, and no period mixes old and new values. The run-control register can only be changed while the timer is stopped. While the timer is stopped, the working registers follow the holding registers, so a timer that starts uses the values written last.

For a period of P cycles with D high cycles, write reload = (MAX − P) + 1 and compare = reload + D − 1, where MAX is the all-ones count.

Top module: `pwm_reload_timer`

## Requirements
- R1: After reset the counter, reload, compare and holding registers are all zero, the timer is stopped and `pwm_o` is low.
- R2: A write happens in any cycle with `wr_en_i` high. `wr_sel_i` selects the target: 0 is run-control, 1 is counter, 2 is reload and 3 is compare.
- R3: Bit 0 of run-control is the start bit. While it is 0 the counter keeps its value and `pwm_o` is low.
- R4: A run-control write made while the timer runs is ignored, and the output keeps its running waveform.
- R5: While running, the counter adds one each cycle. In the cycle after it equals MAX it takes the reload value. A reload of (MAX − P) + 1 gives a period of P cycles.
- R6: While running, `pwm_o` is high while the counter lies from the reload value through the compare value, and low otherwise. A compare of reload + D − 1 gives D high cycles per period.
- R7: Reload and compare writes made while running are held back. Both take effect together on the counter wrap. The period in progress keeps its old period and high time.
- R8: While stopped, the working reload and compare values follow the holding registers one cycle after each write.
- R9: A counter write replaces the count on the next edge and leaves the reload and compare values unchanged. It takes priority over a wrap in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select (0 run-control, 1 counter, 2 reload, 3 compare) |
| wr_data_i | input | CNT_W | Write data |
| pwm_o | output | 1 | PWM output |

## Verification
The output assertions assume the compare value is never below the reload value. The stimulus keeps this true by programming only high times from 1 to P − 1 and by writing both values as a pair. The wrap checks assume that a counter write does not land on the same edge as a wrap unless that case is the one under test. The bench places its writes early in a period and lets it finish before measuring. Every period the bench programs lasts at least three cycles, so both holding writes land before the wrap that commits them.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_COUNT = 2'd1,
    SEL_LOAD  = 2'd2,
    SEL_MATCH = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/pwm_shadow_regs.sv
module pwm_shadow_regs
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic             run_o,
  output logic             cnt_wr_o,
  output logic [CNT_W-1:0] sh_load_o,
  output logic [CNT_W-1:0] sh_match_o
);
  logic run_q;
  logic ctrl_wr, load_wr, match_wr;

  assign ctrl_wr  = wr_en_i && (wr_sel_i == SEL_CTRL);
  assign cnt_wr_o = wr_en_i && (wr_sel_i == SEL_COUNT);
  assign load_wr  = wr_en_i && (wr_sel_i == SEL_LOAD);
  assign match_wr = wr_en_i && (wr_sel_i == SEL_MATCH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q      <= 1'b0;
      sh_load_o  <= '0;
      sh_match_o <= '0;
    end else begin
      // control locked once running
      if (ctrl_wr && !run_q) run_q <= wr_data_i[0];
      if (load_wr)  sh_load_o  <= wr_data_i;
      if (match_wr) sh_match_o <= wr_data_i;
    end
  end

  assign run_o = run_q;

  // R4
  ctrl_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && ctrl_wr) |=> run_q);
endmodule

// File: rtl/pwm_count_core.sv
module pwm_count_core #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             cnt_wr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic [CNT_W-1:0] sh_load_i,
  input  logic [CNT_W-1:0] sh_match_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] act_load_o,
  output logic [CNT_W-1:0] act_match_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic wrap;
  assign wrap = run_i && (count_o == CNT_MAX) && !cnt_wr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_o <= '0;
    end else if (cnt_wr_i) begin
      count_o <= wr_data_i;
    end else if (wrap) begin
      count_o <= sh_load_i;   // new period starts on committed reload
    end else if (run_i) begin
      count_o <= count_o + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_load_o  <= '0;
      act_match_o <= '0;
    end else if (!run_i || wrap) begin
      act_load_o  <= sh_load_i;
      act_match_o <= sh_match_i;
    end
  end

  // R3
  hold_stopped_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !cnt_wr_i) |=> $stable(count_o));
  // R5
  wrap_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |=> (count_o == act_load_o));
  // R7
  commit_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |=> (act_load_o == $past(sh_load_i) && act_match_o == $past(sh_match_i)));
  // R7
  mid_period_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !wrap) |=> ($stable(act_load_o) && $stable(act_match_o)));
  // R9
  count_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_wr_i |=> (count_o == $past(wr_data_i)));
endmodule

// File: rtl/pwm_compare.sv
module pwm_compare #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [CNT_W-1:0] act_load_i,
  input  logic [CNT_W-1:0] act_match_i,
  output logic             pwm_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  assign pwm_o = run_i && (count_i >= act_load_i) && (count_i <= act_match_i);

  // R6
  high_at_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && count_i == act_load_i && act_match_i >= act_load_i) |-> pwm_o);
  // R6
  low_at_max_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_i == CNT_MAX && act_match_i != CNT_MAX) |-> !pwm_o);
endmodule

// File: rtl/pwm_reload_timer.sv
module pwm_reload_timer #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic             pwm_o
);
  logic             run, cnt_wr;
  logic [CNT_W-1:0] sh_load, sh_match, count, act_load, act_match;

  pwm_shadow_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_data_i,
    .run_o(run), .cnt_wr_o(cnt_wr), .sh_load_o(sh_load), .sh_match_o(sh_match)
  );

  pwm_count_core #(.CNT_W(CNT_W)) u_core (
    .clk_i, .rst_ni, .run_i(run), .cnt_wr_i(cnt_wr), .wr_data_i,
    .sh_load_i(sh_load), .sh_match_i(sh_match),
    .count_o(count), .act_load_o(act_load), .act_match_o(act_match)
  );

  pwm_compare #(.CNT_W(CNT_W)) u_cmp (
    .clk_i, .rst_ni, .run_i(run), .count_i(count),
    .act_load_i(act_load), .act_match_i(act_match), .pwm_o
  );

  // R1
  stopped_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |-> !pwm_o);
endmodule

// File: tb/pwm_reload_timer_test.sv
`timescale 1ns/1ps
module pwm_reload_timer_test;
  localparam logic [31:0] MAXV = 32'hFFFF_FFFF;
  localparam int NV = 6;
  // {period, high cycles}
  localparam int unsigned VEC [NV][2] = '{
    '{5, 2}, '{8, 1}, '{3, 2}, '{10, 9}, '{4, 1}, '{7, 3}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_sel_i = '0;
  logic [31:0] wr_data_i = '0;
  logic        pwm_o;
  int checks = 0, errors = 0;
  bit done = 0;

  pwm_reload_timer uut (.clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_data_i, .pwm_o);

  always #10 clk_i = ~clk_i;

  function automatic logic [31:0] ld_of(int p); return (MAXV - p) + 1; endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    wr_en_i = 1'b1; wr_sel_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic wait_rise();
    logic last;
    int n = 0;
    last = pwm_o;
    do begin
      last = pwm_o;
      @(negedge clk_i);
      n++;
    end while (!(pwm_o && !last) && n < 1000);
  endtask

  // entered on the first high sample of a period; ends on the next one
  task automatic meas(bit w, logic [31:0] ld, logic [31:0] mt, output int hi, output int per);
    logic last;
    hi = 0; per = 0;
    do begin
      wr_en_i = w && (per < 2);
      wr_sel_i = (per == 0) ? 2'd2 : 2'd3;
      wr_data_i = (per == 0) ? ld : mt;
      hi += int'(pwm_o);
      per++;
      last = pwm_o;
      @(negedge clk_i);
    end while (!(pwm_o && !last) && per < 1000);
    wr_en_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int hi, per, op, od;
    logic [31:0] ld;
    repeat (3) @(negedge clk_i);
    chk(pwm_o == 1'b0, "R1 low in reset", pwm_o, 0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    chk(pwm_o == 1'b0, "R1 low after reset", pwm_o, 0);

    // R2 R8: program while stopped, then hold for a while
    op = 6; od = 3; ld = ld_of(op);
    wr(2'd2, ld); wr(2'd3, ld + od - 1); wr(2'd1, ld);
    repeat (10) @(negedge clk_i);
    chk(pwm_o == 1'b0, "R3 stopped output low", pwm_o, 0);
    wr(2'd0, 32'd1);
    meas(0, '0, '0, hi, per);
    chk(hi == od, "R3 R8 first period high", hi, od);
    chk(per == op, "R3 R8 first period length", per, op);

    // vector walk: write mid-period, old period finishes, then new applies
    for (int i = 0; i < NV; i++) begin
      int p = int'(VEC[i][0]);
      int d = int'(VEC[i][1]);
      ld = ld_of(p);
      meas(1, ld, ld + d - 1, hi, per);
      chk(hi == od, "R7 old high kept", hi, od);
      chk(per == op, "R7 old period kept", per, op);
      meas(0, '0, '0, hi, per);
      chk(hi == d, "R6 new high", hi, d);
      chk(per == p, "R5 new period", per, p);
      op = p; od = d;
    end

    // R9: force counter to MAX on first high cycle
    wr_en_i = 1'b1; wr_sel_i = 2'd1; wr_data_i = MAXV;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    chk(pwm_o == 1'b0, "R9 count at MAX low", pwm_o, 0);
    @(negedge clk_i);
    chk(pwm_o == 1'b1, "R9 reload after MAX", pwm_o, 1);
    meas(0, '0, '0, hi, per);
    chk(hi == od, "R9 settings kept high", hi, od);
    chk(per == op, "R9 settings kept period", per, op);

    // R4: attempt stop while running
    wr(2'd0, 32'd0);
    chk(pwm_o == 1'b1, "R4 still running", pwm_o, 1);
    wait_rise();
    meas(0, '0, '0, hi, per);
    chk(hi == od, "R4 high unchanged", hi, od);
    chk(per == op, "R4 period unchanged", per, op);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule